// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the control and status registers of one 32-bit bus-master DMA channel that sits next to a SCSI core. Software programs a starting byte count, a starting address and a descriptor-list address. It then writes a command word whose low two bits pick the operation. A start command copies the three starting values into working copies and enables the core's DMA path. Idle disables that path. Abort sends a one-cycle cancel pulse to the core. Blast has no effect.

A simple transfer-request port lets the data path ask to move a number of bytes. The block grants no more than the bytes left in the working count, one cycle later. It then lowers the working count and raises the working address by the granted amount. A request whose direction disagrees with the command's direction bit is dropped. When the core reports that its command is complete, the working count goes to zero and the done status bit is set. The status register can be cleared in two ways, chosen by one bit of a separate bus-and-control register: write-one-to-clear, or clear-on-read. Descriptor-list mode is flagged as unsupported.

Top module: `dmac_regs`

## Requirements
- R1: After reset, the command register reads 0 and the working count reads 0. The working address reads 0xFFFFFFFF, the working list address reads 0xFFFFFFFD, the status reads 0 and dma_en_o is low.
- R2: The register index map is: 0 command, 1 starting count, 2 starting address, 6 starting list address, 3 working count, 4 working address, 7 working list address, 5 status, 12 bus-and-control. The starting registers, command and bus-and-control registers read back what was written. Writes to indices 3, 4 and 7 are ignored.
- R3: A command write with bits 1:0 = 3 (start) copies the starting count, starting address and starting list address into the working count, working address and working list address. It clears every stored status bit and drives dma_en_o high from the next cycle.
- R4: A command write with bits 1:0 = 0 (idle) drives dma_en_o low from the next cycle. Bits 1:0 = 1 (blast) changes neither dma_en_o nor any working register.
- R5: A command write with bits 1:0 = 2 (abort) gives a single-cycle cancel_o pulse in the next cycle and sets status bit 2 (abort).
- R6: A status read returns stored bits 1 (error), 2 (abort) and 3 (done). Bit 4 is not stored: it equals core_irq_i at the time of the read.
- R7: When bus-and-control bit 12 is 0, a status write clears each of bits 1, 2 and 3 that has a one in the written data. The other bits are left as they were.
- R8: When bus-and-control bit 12 is 1, status writes are ignored, and a status read returns the bits and then clears bits 1, 2 and 3.
- R9: A transfer request whose direction matches command bit 7 (1 = device to memory) is granted in the next cycle. The granted length is the smaller of the requested length and the working count, and the grant address is the working address before the grant. The working count falls by the granted length and the working address rises by it.
- R10: A transfer request whose direction differs from command bit 7 gives no grant and leaves the working count and the working address unchanged.
- R11: A core_done_i pulse sets the working count to 0 and sets status bit 3 (done).
- R12: list_unsup_o is high whenever command bit 4 (descriptor-list mode) is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (matters only for clear-on-read) |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| core_irq_i | input | 1 | Interrupt flag from the SCSI core |
| core_done_i | input | 1 | Core command completion pulse |
| dma_en_o | output | 1 | DMA enable to the core |
| cancel_o | output | 1 | One-cycle cancel pulse to the core |
| xfer_req_i | input | 1 | Transfer request |
| xfer_to_mem_i | input | 1 | Request direction, 1 = device to memory |
| xfer_len_i | input | 32 | Requested byte count |
| grant_o | output | 1 | Grant pulse |
| grant_len_o | output | 32 | Granted byte count |
| grant_addr_o | output | 32 | Address of the granted bytes |
| list_unsup_o | output | 1 | Descriptor-list mode selected, unsupported |

## Verification
The bench builds the block with its default 32-bit data width and clear-mode select at bit 12, so the reset values 0xFFFFFFFF and 0xFFFFFFFD appear in full. A starting count of 100 is small enough for a handful of table-driven requests to reach both the clamp and an empty count. In that table, zero-length grants and a wrong-direction request are mixed in with normal grants. Both clear modes are driven with two status bits set at once, so a partial clear and an ignored write can each be seen.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned STAT_W = 6;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam logic [IDX_W-1:0] IDX_CMD  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SCNT = 4'd1;
  localparam logic [IDX_W-1:0] IDX_SADR = 4'd2;
  localparam logic [IDX_W-1:0] IDX_WCNT = 4'd3;
  localparam logic [IDX_W-1:0] IDX_WADR = 4'd4;
  localparam logic [IDX_W-1:0] IDX_STAT = 4'd5;
  localparam logic [IDX_W-1:0] IDX_SLST = 4'd6;
  localparam logic [IDX_W-1:0] IDX_WLST = 4'd7;
  localparam logic [IDX_W-1:0] IDX_BCTL = 4'd12;

  localparam int unsigned CMD_DIR_BIT  = 7;
  localparam int unsigned CMD_LIST_BIT = 4;

  localparam int unsigned ST_PWDN = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_ABT  = 2;
  localparam int unsigned ST_DONE = 3;
  localparam int unsigned ST_IRQ  = 4;
  localparam int unsigned ST_BCM  = 5;

  localparam logic [STAT_W-1:0] ST_CLRABLE = 6'b001110;
endpackage

// File: rtl/dmac_cmd_ctrl.sv
module dmac_cmd_ctrl
  import dmac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cmd_o,
  output logic          start_o,
  output logic          abort_o,
  output logic          dma_en_o,
  output logic          cancel_o
);
  logic [DW-1:0] cmd_q;
  logic          en_q, cancel_q;
  dma_op_e       op;

  assign op      = dma_op_e'(wdata_i[1:0]);
  assign start_o = cmd_we_i && (op == OP_START);
  assign abort_o = cmd_we_i && (op == OP_ABORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      en_q     <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      cancel_q <= abort_o;
      if (cmd_we_i) begin
        cmd_q <= wdata_i;
        unique case (op)
          OP_START: en_q <= 1'b1;
          OP_IDLE:  en_q <= 1'b0;
          default:  en_q <= en_q;  // blast and abort keep enable
        endcase
      end
    end
  end

  assign cmd_o    = cmd_q;
  assign dma_en_o = en_q;
  assign cancel_o = cancel_q;
endmodule

// File: rtl/dmac_status.sv
module dmac_status
  import dmac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              done_i,
  input  logic              w1c_we_i,
  input  logic [STAT_W-1:0] w1c_data_i,
  input  logic              cor_re_i,
  input  logic              irq_i,
  output logic [STAT_W-1:0] stored_o,
  output logic [STAT_W-1:0] view_o
);
  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (w1c_we_i) stat_d = stat_d & ~(w1c_data_i & ST_CLRABLE);
    if (cor_re_i) stat_d = stat_d & ~ST_CLRABLE;
    if (start_i)  stat_d = '0;
    if (abort_i)  stat_d[ST_ABT] = 1'b1;
    if (done_i)   stat_d[ST_DONE] = 1'b1;
    stat_d[ST_IRQ] = 1'b0;  // never stored
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stored_o = stat_q;
  always_comb begin
    view_o         = stat_q;
    view_o[ST_IRQ] = irq_i;
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int unsigned   DW       = 32,
  parameter logic [DW-1:0] WADR_RST = '1,
  parameter logic [DW-1:0] WLST_RST = WADR_RST - DW'(2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic [DW-1:0] scnt_i,
  input  logic [DW-1:0] sadr_i,
  input  logic [DW-1:0] slst_i,
  input  logic          dir_i,
  input  logic          req_i,
  input  logic          req_to_mem_i,
  input  logic [DW-1:0] req_len_i,
  output logic [DW-1:0] wcnt_o,
  output logic [DW-1:0] wadr_o,
  output logic [DW-1:0] wlst_o,
  output logic          grant_o,
  output logic [DW-1:0] grant_len_o,
  output logic [DW-1:0] grant_adr_o
);
  logic [DW-1:0] wcnt_q, wadr_q, wlst_q, glen;
  logic          accept;
  logic          grant_q;
  logic [DW-1:0] glen_q, gadr_q;

  assign accept = req_i && (req_to_mem_i == dir_i);
  assign glen   = (req_len_i < wcnt_q) ? req_len_i : wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      wadr_q  <= WADR_RST;
      wlst_q  <= WLST_RST;
      grant_q <= 1'b0;
      glen_q  <= '0;
      gadr_q  <= '0;
    end else begin
      grant_q <= accept;
      if (accept) begin
        glen_q <= glen;
        gadr_q <= wadr_q;
        wcnt_q <= wcnt_q - glen;
        wadr_q <= wadr_q + glen;
      end
      if (start_i) begin
        wcnt_q <= scnt_i;
        wadr_q <= sadr_i;
        wlst_q <= slst_i;
      end
      if (done_i) wcnt_q <= '0;  // completion wins over all
    end
  end

  assign wcnt_o      = wcnt_q;
  assign wadr_o      = wadr_q;
  assign wlst_o      = wlst_q;
  assign grant_o     = grant_q;
  assign grant_len_o = glen_q;
  assign grant_adr_o = gadr_q;
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned CLR_SEL_BIT = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [IDX_W-1:0] reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             core_irq_i,
  input  logic             core_done_i,
  output logic             dma_en_o,
  output logic             cancel_o,
  input  logic             xfer_req_i,
  input  logic             xfer_to_mem_i,
  input  logic [DW-1:0]    xfer_len_i,
  output logic             grant_o,
  output logic [DW-1:0]    grant_len_o,
  output logic [DW-1:0]    grant_addr_o,
  output logic             list_unsup_o
);
  localparam logic [DW-1:0] WADR_RST = '1;
  localparam logic [DW-1:0] WLST_RST = WADR_RST - DW'(2);

  logic [DW-1:0] scnt_q, sadr_q, slst_q, bctl_q;
  logic [DW-1:0] cmd, wcnt, wadr, wlst;
  logic [STAT_W-1:0] stat_q, stat_view;
  logic start, abort_cmd, cor_mode;
  logic we_cmd, we_stat, re_stat;

  assign we_cmd   = reg_we_i && (reg_addr_i == IDX_CMD);
  assign we_stat  = reg_we_i && (reg_addr_i == IDX_STAT);
  assign re_stat  = reg_re_i && (reg_addr_i == IDX_STAT);
  assign cor_mode = bctl_q[CLR_SEL_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scnt_q <= '0;
      sadr_q <= '0;
      slst_q <= '0;
      bctl_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        IDX_SCNT: scnt_q <= reg_wdata_i;
        IDX_SADR: sadr_q <= reg_wdata_i;
        IDX_SLST: slst_q <= reg_wdata_i;
        IDX_BCTL: bctl_q <= reg_wdata_i;
        default:  ;
      endcase
    end
  end

  dmac_cmd_ctrl #(.DW(DW)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (we_cmd),
    .wdata_i  (reg_wdata_i),
    .cmd_o    (cmd),
    .start_o  (start),
    .abort_o  (abort_cmd),
    .dma_en_o (dma_en_o),
    .cancel_o (cancel_o)
  );

  dmac_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort_cmd),
    .done_i     (core_done_i),
    .w1c_we_i   (we_stat && !cor_mode),
    .w1c_data_i (reg_wdata_i[STAT_W-1:0]),
    .cor_re_i   (re_stat && cor_mode),
    .irq_i      (core_irq_i),
    .stored_o   (stat_q),
    .view_o     (stat_view)
  );

  dmac_chan #(.DW(DW), .WADR_RST(WADR_RST), .WLST_RST(WLST_RST)) u_chan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .done_i       (core_done_i),
    .scnt_i       (scnt_q),
    .sadr_i       (sadr_q),
    .slst_i       (slst_q),
    .dir_i        (cmd[CMD_DIR_BIT]),
    .req_i        (xfer_req_i),
    .req_to_mem_i (xfer_to_mem_i),
    .req_len_i    (xfer_len_i),
    .wcnt_o       (wcnt),
    .wadr_o       (wadr),
    .wlst_o       (wlst),
    .grant_o      (grant_o),
    .grant_len_o  (grant_len_o),
    .grant_adr_o  (grant_addr_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      IDX_CMD:  reg_rdata_o = cmd;
      IDX_SCNT: reg_rdata_o = scnt_q;
      IDX_SADR: reg_rdata_o = sadr_q;
      IDX_WCNT: reg_rdata_o = wcnt;
      IDX_WADR: reg_rdata_o = wadr;
      IDX_STAT: reg_rdata_o = DW'(stat_view);
      IDX_SLST: reg_rdata_o = slst_q;
      IDX_WLST: reg_rdata_o = wlst;
      IDX_BCTL: reg_rdata_o = bctl_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign list_unsup_o = cmd[CMD_LIST_BIT];
endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk
  import dmac_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [IDX_W-1:0]  reg_addr_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic              dma_en_o,
  input logic              cancel_o,
  input logic              xfer_req_i,
  input logic              xfer_to_mem_i,
  input logic              grant_o,
  input logic [DW-1:0]     grant_len_o,
  input logic [DW-1:0]     wcnt,
  input logic [DW-1:0]     cmd,
  input logic              core_done_i,
  input logic [STAT_W-1:0] stat_q
);
  logic cmd_wr;
  assign cmd_wr = reg_we_i && (reg_addr_i == IDX_CMD);

  assert_start_enables_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[1:0] == 2'd3) |=> dma_en_o);

  assert_idle_disables_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[1:0] == 2'd0) |=> !dma_en_o);

  assert_abort_cancels_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[1:0] == 2'd2) |=> (cancel_o && stat_q[ST_ABT]));

  assert_grant_clamped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (grant_len_o <= $past(wcnt)));

  assert_dir_mismatch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_i && (xfer_to_mem_i != cmd[CMD_DIR_BIT])) |=> !grant_o);

  assert_done_update_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_done_i |=> (wcnt == '0 && stat_q[ST_DONE]));
endmodule

bind dmac_regs dmac_regs_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .dma_en_o      (dma_en_o),
  .cancel_o      (cancel_o),
  .xfer_req_i    (xfer_req_i),
  .xfer_to_mem_i (xfer_to_mem_i),
  .grant_o       (grant_o),
  .grant_len_o   (grant_len_o),
  .wcnt          (wcnt),
  .cmd           (cmd),
  .core_done_i   (core_done_i),
  .stat_q        (stat_q)
);

// File: tb/dmac_regs_tb_top.sv
module dmac_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq = 1'b0, done = 1'b0;
  logic        dma_en, cancel;
  logic        req = 1'b0, to_mem = 1'b0;
  logic [31:0] len = '0;
  logic        grant;
  logic [31:0] glen, gadr;
  logic        unsup;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dmac_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .core_irq_i(irq), .core_done_i(done),
    .dma_en_o(dma_en), .cancel_o(cancel),
    .xfer_req_i(req), .xfer_to_mem_i(to_mem), .xfer_len_i(len),
    .grant_o(grant), .grant_len_o(glen), .grant_addr_o(gadr),
    .list_unsup_o(unsup)
  );

  typedef struct packed {
    logic        grant;
    logic        to_mem;
    logic [15:0] len;
    logic [15:0] exp_len;
    logic [15:0] exp_cnt;
    logic [15:0] exp_adr;
  } vec_t;

  // start count 100, address 0x1000, direction device-to-memory
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 16'd10, 16'd10, 16'd90, 16'h100A},
    '{1'b0, 1'b0, 16'd5,  16'd0,  16'd90, 16'h100A},
    '{1'b1, 1'b1, 16'd40, 16'd40, 16'd50, 16'h1032},
    '{1'b1, 1'b1, 16'd0,  16'd0,  16'd50, 16'h1032},
    '{1'b1, 1'b1, 16'd60, 16'd50, 16'd0,  16'h1064},
    '{1'b1, 1'b1, 16'd7,  16'd0,  16'd0,  16'h1064}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] prev_adr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v);  chk("R1 cmd", v, 32'h0);
    rd(4'd3, v);  chk("R1 wcnt", v, 32'h0);
    rd(4'd4, v);  chk("R1 wadr", v, 32'hFFFF_FFFF);
    rd(4'd7, v);  chk("R1 wlst", v, 32'hFFFF_FFFD);
    rd(4'd5, v);  chk("R1 stat", v, 32'h0);
    chk("R1 dma_en", {31'd0, dma_en}, 32'd0);

    // R2 map and readback, writes to working registers ignored
    wr(4'd1, 32'd100);
    wr(4'd2, 32'h0000_1000);
    wr(4'd6, 32'h0000_8000);
    rd(4'd1, v);  chk("R2 scnt", v, 32'd100);
    rd(4'd2, v);  chk("R2 sadr", v, 32'h1000);
    rd(4'd6, v);  chk("R2 slst", v, 32'h8000);
    wr(4'd3, 32'h55);
    wr(4'd4, 32'h66);
    wr(4'd7, 32'h77);
    rd(4'd3, v);  chk("R2 wcnt write ignored", v, 32'h0);
    rd(4'd4, v);  chk("R2 wadr write ignored", v, 32'hFFFF_FFFF);
    rd(4'd7, v);  chk("R2 wlst write ignored", v, 32'hFFFF_FFFD);

    // R5 abort pulse and status bit; R11 done bit
    wr(4'd0, 32'h0000_0002);
    chk("R5 cancel pulse", {31'd0, cancel}, 32'd1);
    @(negedge clk);
    chk("R5 cancel single cycle", {31'd0, cancel}, 32'd0);
    pulse_done();
    rd(4'd5, v);  chk("R5 R11 stat abort+done", v, 32'h0C);

    // R3 start
    wr(4'd0, 32'h0000_0083);
    chk("R3 dma_en", {31'd0, dma_en}, 32'd1);
    rd(4'd3, v);  chk("R3 wcnt", v, 32'd100);
    rd(4'd4, v);  chk("R3 wadr", v, 32'h1000);
    rd(4'd7, v);  chk("R3 wlst", v, 32'h8000);
    rd(4'd5, v);  chk("R3 stat cleared", v, 32'h0);
    rd(4'd0, v);  chk("R2 cmd readback", v, 32'h83);

    // R9 R10 transfer table
    prev_adr = 32'h1000;
    foreach (VECS[i]) begin
      @(negedge clk);
      req = 1'b1; to_mem = VECS[i].to_mem; len = 32'(VECS[i].len);
      @(negedge clk);
      req = 1'b0;
      chk(VECS[i].grant ? "R9 grant" : "R10 no grant", {31'd0, grant}, {31'd0, VECS[i].grant});
      if (VECS[i].grant) begin
        chk("R9 grant len", glen, 32'(VECS[i].exp_len));
        chk("R9 grant addr", gadr, prev_adr);
      end
      rd(4'd3, v);  chk("R9 R10 wcnt", v, 32'(VECS[i].exp_cnt));
      rd(4'd4, v);  chk("R9 R10 wadr", v, 32'(VECS[i].exp_adr));
      prev_adr = 32'(VECS[i].exp_adr);
    end

    // R4 blast no effect, idle disables
    wr(4'd0, 32'h0000_0083);
    wr(4'd0, 32'h0000_0081);
    chk("R4 blast keeps enable", {31'd0, dma_en}, 32'd1);
    rd(4'd3, v);  chk("R4 blast wcnt", v, 32'd100);
    rd(4'd4, v);  chk("R4 blast wadr", v, 32'h1000);
    wr(4'd0, 32'h0000_0080);
    chk("R4 idle disables", {31'd0, dma_en}, 32'd0);

    // R11 completion
    pulse_done();
    rd(4'd3, v);  chk("R11 wcnt zero", v, 32'h0);

    // R6 R7 write-one-to-clear mode
    wr(4'd0, 32'h0000_0082);
    irq = 1'b1;
    rd(4'd5, v);  chk("R6 stat with irq", v, 32'h1C);
    irq = 1'b0;
    wr(4'd5, 32'h0000_0008);
    rd(4'd5, v);  chk("R7 partial clear", v, 32'h04);
    rd(4'd5, v);  chk("R7 read does not clear", v, 32'h04);

    // R8 clear-on-read mode
    wr(4'd12, 32'h0000_1000);
    rd(4'd12, v); chk("R2 bctl readback", v, 32'h1000);
    pulse_done();
    wr(4'd5, 32'h0000_000C);
    rd(4'd5, v);  chk("R8 write ignored", v, 32'h0C);
    rd(4'd5, v);  chk("R8 cleared by read", v, 32'h0);

    // R12 descriptor-list mode flag
    chk("R12 unsup low", {31'd0, unsup}, 32'd0);
    wr(4'd0, 32'h0000_0010);
    chk("R12 unsup high", {31'd0, unsup}, 32'd1);

    finish_run();
  end
endmodule